// File: doc/BRIEF.md
# Coarse Depth Early Quad Reject

This block keeps a coarse depth map for the whole depth buffer. Each entry covers one 4x4 pixel block and holds an 8-bit farthest-depth value. It tests incoming 4x4 fragment quads against that map before they reach texturing. A quad whose nearest depth lies strictly behind everything already stored for its block is rejected, so it costs no texture fetches and no fill. Every other quad passes on to the fine per-pixel depth test. The depth test is less-than, so larger values are farther away.

The full-precision depth stage sends a new block maximum over the update port. The block rounds that value up to 8 bits, which means the stored value is never nearer than the true one. Quad depths are rounded down to 8 bits. Because of these two roundings, the coarse test cannot reject a pixel that would have been visible. Several check lanes run in parallel, one quad per lane per cycle, so that the pixel rate holds even though the blocks are small. A clear marks every entry as farthest, which turns rejection off until new maxima arrive.

Top module: `hz_tile_reject`

## Requirements
- R1: After reset, every coarse entry holds 255, r_valid is 0 in every lane and q_ready is 1 in every lane.
- R2: A lane accepts a quad when q_valid and q_ready are both 1. Exactly one cycle later its r_valid is 1; in every other cycle r_valid is 0.
- R3: An update stores the 24-bit maximum rounded up to 8 bits. The stored value is bits [23:16], plus one when bits [15:0] are not zero, and it saturates at 255.
- R4: r_reject is 1 exactly when the quad's nearest depth bits [23:16] are strictly greater than the coarse entry its block index selects (r_reject=1 means reject, 0 means pass).
- R5: A quad whose nearest depth is at or in front of the last full-precision maximum written for its block is never rejected.
- R6: When an update and a quad name the same block in the same cycle, the quad is tested against the updated value.
- R7: While clr is 1, q_ready is 0 in every lane and all entries become 255. A clear takes priority over an update in the same cycle, and no result appears in the cycle after a clear.
- R8: The lanes work independently. Two lanes may test the same block or different blocks in the same cycle, and each lane gets its own correct result.
- R9: An update changes only the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear all coarse entries to farthest |
| upd_valid | input | 1 | Block maximum update strobe |
| upd_idx | input | IW | Block index of the update |
| upd_zmax | input | ZW | Full-precision farthest depth of the block |
| q_valid | input | LANES | Quad present, one bit per lane |
| q_ready | output | LANES | Lane can accept a quad |
| q_idx | input | LANES*IW | Block index per lane, lane l at [l*IW +: IW] |
| q_zmin | input | LANES*ZW | Nearest quad depth per lane, lane l at [l*ZW +: ZW] |
| r_valid | output | LANES | Result present, one cycle after accept |
| r_reject | output | LANES | 1 = quad hidden, drop it; 0 = pass |

## Verification
A wrong coarse entry shows up as a wrong verdict on the very next quad that tests that block. If the entry is too near, visible quads are rejected and leave holes. If it is too far, hidden quads pass and the culling is lost. The bench keeps a reference copy of all entries and compares the verdict of every lane one cycle after acceptance. Rounding errors are caught by maxima placed exactly on the 8-bit boundary and at the saturation point. Ordering errors are caught by same-cycle update and quad pairs, and by a clear issued together with an update.

// File: rtl/hz_tile_reject.sv
module hz_tile_reject #(
  parameter int LANES  = 2,
  parameter int BLOCKS = 64,
  parameter int ZW     = 24,
  parameter int CW     = 8,
  localparam int IW    = $clog2(BLOCKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd_valid,
  input  logic [IW-1:0]       upd_idx,
  input  logic [ZW-1:0]       upd_zmax,
  input  logic [LANES-1:0]    q_valid,
  output logic [LANES-1:0]    q_ready,
  input  logic [LANES*IW-1:0] q_idx,
  input  logic [LANES*ZW-1:0] q_zmin,
  output logic [LANES-1:0]    r_valid,
  output logic [LANES-1:0]    r_reject
);

  function automatic logic [CW-1:0] round_up(input logic [ZW-1:0] z);
    logic [CW:0] s;
    s = {1'b0, z[ZW-1 -: CW]} + {{CW{1'b0}}, |z[ZW-CW-1:0]};
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  logic [CW-1:0] cz [BLOCKS];
  logic [CW-1:0] upd_q;
  logic          upd_live;

  assign upd_q    = round_up(upd_zmax);
  assign upd_live = upd_valid & ~clr;
  assign q_ready  = {LANES{~clr}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int b = 0; b < BLOCKS; b++) cz[b] <= {CW{1'b1}};
    end else if (upd_valid) begin
      cz[upd_idx] <= upd_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IW-1:0] idx;
    logic [CW-1:0] near_q, far_q;
    logic          take;

    assign idx    = q_idx[l*IW +: IW];
    assign near_q = q_zmin[l*ZW+ZW-1 -: CW];
    assign far_q  = (upd_live && upd_idx == idx) ? upd_q : cz[idx];
    assign take   = q_valid[l] & q_ready[l];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_valid[l]  <= 1'b0;
        r_reject[l] <= 1'b0;
      end else begin
        r_valid[l]  <= take;
        r_reject[l] <= take && (near_q > far_q);
      end
    end
  end

endmodule

module hz_tile_reject_chk #(
  parameter int LANES = 2,
  parameter int ZW    = 24,
  parameter int CW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [LANES-1:0] q_valid,
  input logic [LANES-1:0] q_ready,
  input logic [LANES*ZW-1:0] q_zmin,
  input logic [LANES-1:0] r_valid,
  input logic [LANES-1:0] r_reject
);
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r2_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (r_valid[l] == $past(q_valid[l] && q_ready[l])));
    a_r4_reject_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      r_reject[l] |-> r_valid[l]);
    a_r7_quiet_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(clr)) |-> !r_valid[l]);
    a_r5_reject_needs_depth: assert property (@(posedge clk) disable iff (!rst_n)
      r_reject[l] |-> ($past(q_zmin[l*ZW+ZW-1 -: CW]) != '0));
  end
endmodule

bind hz_tile_reject hz_tile_reject_chk #(.LANES(LANES), .ZW(ZW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .q_valid(q_valid), .q_ready(q_ready),
  .q_zmin(q_zmin), .r_valid(r_valid), .r_reject(r_reject));

// File: tb/sim_hz_tile_reject.sv
module sim_hz_tile_reject;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2, BLOCKS = 64, ZW = 24, IW = 6;

  logic clk = 0, rst_n = 0, clr = 0, upd_valid = 0;
  logic [IW-1:0] upd_idx = 0;
  logic [ZW-1:0] upd_zmax = 0;
  logic [LANES-1:0] q_valid = 0, q_ready, r_valid, r_reject;
  logic [LANES*IW-1:0] q_idx = 0;
  logic [LANES*ZW-1:0] q_zmin = 0;

  hz_tile_reject u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int mem [BLOCKS];
  bit bqv [LANES];
  int bqi [LANES];
  int bqz [LANES];
  bit bclr, buv;
  int bui, buz;

  function automatic int cq(int z);
    int t = (z >> 16) + (((z & 16'hFFFF) != 0) ? 1 : 0);
    return (t > 255) ? 255 : t;
  endfunction

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    bclr = 0; buv = 0; bui = 0; buz = 0;
    for (int l = 0; l < LANES; l++) begin bqv[l] = 0; bqi[l] = 0; bqz[l] = 0; end
  endtask

  task automatic cycle(string tag);
    bit ev [LANES];
    bit er [LANES];
    clr = bclr; upd_valid = buv; upd_idx = bui[IW-1:0]; upd_zmax = buz[ZW-1:0];
    for (int l = 0; l < LANES; l++) begin
      int eff;
      q_valid[l] = bqv[l];
      q_idx[l*IW +: IW] = bqi[l][IW-1:0];
      q_zmin[l*ZW +: ZW] = bqz[l][ZW-1:0];
      eff = (buv && !bclr && bui == bqi[l]) ? cq(buz) : mem[bqi[l]];
      ev[l] = bqv[l] && !bclr;
      er[l] = ev[l] && ((bqz[l] >> 16) > eff);
    end
    #1;
    check({tag, " R7 ready"}, int'(q_ready), bclr ? 0 : (1 << LANES) - 1);
    if (bclr) for (int b = 0; b < BLOCKS; b++) mem[b] = 255;
    else if (buv) mem[bui] = cq(buz);
    @(posedge clk); @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      check({tag, " R2 valid"}, int'(r_valid[l]), int'(ev[l]));
      check({tag, " R4 reject"}, int'(r_reject[l]), int'(er[l]));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual hang expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int b = 0; b < BLOCKS; b++) mem[b] = 255;
    idle();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(r_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", int'(q_ready), 3);
    // R1: farthest quad on untouched blocks passes
    bqv[0] = 1; bqi[0] = 0; bqz[0] = 24'hFFFFFF;
    bqv[1] = 1; bqi[1] = 63; bqz[1] = 24'hFFFFFF;
    cycle("R1 init"); idle();
    // R3: exact boundary, no round up
    buv = 1; bui = 5; buz = 24'h400000; cycle("R3 exact"); idle();
    bqv[0] = 1; bqi[0] = 5; bqz[0] = 24'h41_0000;
    bqv[1] = 1; bqi[1] = 5; bqz[1] = 24'h40_FFFF;
    cycle("R3 R4 R8 boundary"); idle();
    // R3: round up and R5 no false reject
    buv = 1; bui = 6; buz = 24'h400001; cycle("R3 up"); idle();
    bqv[0] = 1; bqi[0] = 6; bqz[0] = 24'h41_0000;
    bqv[1] = 1; bqi[1] = 6; bqz[1] = 24'h42_0000;
    cycle("R5 R3 round"); idle();
    // R3 saturation
    buv = 1; bui = 7; buz = 24'hFF0001; cycle("R3 sat"); idle();
    bqv[0] = 1; bqi[0] = 7; bqz[0] = 24'hFFFFFF; cycle("R3 sat test"); idle();
    // R9: block 8 unaffected by update of 5
    bqv[1] = 1; bqi[1] = 8; bqz[1] = 24'hF00000; cycle("R9 other"); idle();
    // R6 same-cycle update first
    buv = 1; bui = 9; buz = 24'h100000;
    bqv[0] = 1; bqi[0] = 9; bqz[0] = 24'h200000;
    bqv[1] = 1; bqi[1] = 10; bqz[1] = 24'h200000;
    cycle("R6 fwd"); idle();
    // R7 clear wins over update
    bclr = 1; buv = 1; bui = 9; buz = 24'h010000;
    bqv[0] = 1; bqi[0] = 9; bqz[0] = 24'hFFFFFF;
    cycle("R7 clear"); idle();
    bqv[0] = 1; bqi[0] = 9; bqz[0] = 24'hFFFFFF;
    bqv[1] = 1; bqi[1] = 5; bqz[1] = 24'hFFFFFF;
    cycle("R7 after"); idle();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bclr = ($urandom_range(0, 99) == 0);
      buv = $urandom_range(0, 1);
      bui = $urandom_range(0, 7);
      buz = $urandom_range(0, 3) == 0 ? ($urandom_range(0, 255) << 16)
                                      : $urandom_range(0, 24'hFFFFFF);
      for (int l = 0; l < LANES; l++) begin
        bqv[l] = ($urandom_range(0, 3) != 0);
        bqi[l] = $urandom_range(0, 7);
        bqz[l] = (mem[bqi[l]] << 16) + $urandom_range(0, 24'h02FFFF) - 24'h010000;
        if (bqz[l] < 0) bqz[l] = 0;
        if (bqz[l] > 24'hFFFFFF) bqz[l] = 24'hFFFFFF;
      end
      cycle("R4 R8 random");
    end
    idle();
    finish_run();
  end
endmodule